// File: doc/BRIEF.md
# Dual-Clock FIFO with Occupancy-Tracking Almost-Empty Flag

This block moves data words from a producer clocked by one clock to a consumer clocked by another clock with no known phase or frequency relation. Words are stored in a dual-ported register array that is written on the write clock and read on the read clock. Only the pointers cross between the two domains. Each pointer is one bit wider than the address, is converted to Gray code, and passes through a chain of synchronizer flops.

The read side compares its own view of the occupancy with a programmable threshold to raise an almost-empty warning. This view is the write pointer as synchronized into the read domain, minus the local read pointer, and it is also visible on a port. The warning therefore follows the fill level both when the buffer drains and when it fills from empty, including a threshold of one. Reads lower the count at once in the read domain, so empty and almost-empty assert on the next read-clock edge. Writes become visible only after the synchronizer stages, so the release of both flags lags. In every case the flags err toward the safe side.

Top module: `dcfifo_ae`

## Requirements
- R1: After both resets are released, full is 0, empty is 1, almost_empty is 1 and rd_count is 0.
- R2: Words are delivered on rdata in the order they were accepted. rdata is registered and updates on the read-clock edge that consumes the word.
- R3: A write presented while full is 1 is dropped. The write pointer does not move and the stored contents are not disturbed.
- R4: A read presented while empty is 1 is ignored. The read pointer does not move and the next word written is the next word read.
- R5: almost_empty is 1 whenever the occupancy is at or below ae_level. This holds whether that level was reached by reading down or by writing up from empty, including a single write with ae_level = 1.
- R6: A read that brings the read-side count to the threshold, or to zero, raises almost_empty (or empty) on the same read-clock edge that performs the read, with no synchronizer delay.
- R7: A write becomes visible in the read domain only after at least SYNC_STAGES read-clock edges. Once the write side has been idle for SYNC_STAGES+2 read-clock edges, empty and almost_empty have released to their true values.
- R8: full is 1 whenever DEPTH = 2^ADDR_W words are held, and it never releases before the consumer has actually read.
- R9: rd_count never exceeds DEPTH and equals the true occupancy once the write side has been idle for SYNC_STAGES+2 read-clock edges.
- R10: The Gray-coded form of each pointer changes in exactly one bit per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | Buffer full; writes are dropped |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| ae_level | input | ADDR_W+1 | Almost-empty threshold, compared as count <= ae_level |
| rdata | output | DATA_W | Registered read data |
| empty | output | 1 | No word visible to the read side |
| almost_empty | output | 1 | Read-side count at or below ae_level |
| rd_count | output | ADDR_W+1 | Occupancy as seen in the read domain |

## Verification
The bench builds the block with DATA_W = 8, ADDR_W = 3 (eight words) and SYNC_STAGES = 2. The shallow depth makes full reachable and the 3-bit address wrap happen many times within a short random run. A two-stage synchronizer keeps the release lag short enough to check within a fixed window. The write clock runs at 50 MHz and the read clock runs slightly slower on an unrelated period, so the phase of the two clocks sweeps through near-coincident edges. Directed phases cover the fill-from-empty case with a threshold of one, the drain case with a larger threshold, and reads and writes against the empty and full boundaries.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = store[raddr];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_async,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_fire,
  output logic              full
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rgray_s, rbin_s, used;
  logic [31:0]   rbin_w, wgray_w;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_async), .q(rgray_s)
  );

  assign rbin_w = gray2bin(32'(rgray_s));
  assign rbin_s = rbin_w[PW-1:0];
  assign used   = wbin_q - rbin_s;
  assign full   = (used == PW'(DEPTH));
  assign wr_fire = wr_en && !full;

  always_comb begin
    wbin_d  = wbin_q;
    if (wr_fire) wbin_d = wbin_q + 1'b1;
    wgray_w = bin2gray(32'(wbin_d));
    wgray_d = wgray_w[PW-1:0];
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign wgray = wgray_q;
  assign waddr = wbin_q[ADDR_W-1:0];

  // R3: dropped write leaves the pointer in place
  a_r3_hold_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wbin_q));
  // R10: one Gray bit per accepted write
  a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_fire |=> ($countones(wgray_q ^ $past(wgray_q)) == 1));
  // R10: no Gray change without a write
  a_r10_wgray_idle: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_fire |=> $stable(wgray_q));
  // R8: write-side view never exceeds capacity
  a_r8_used_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    used <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   ae_level,
  input  logic [ADDR_W:0]   wgray_async,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_fire,
  output logic              empty,
  output logic              almost_empty,
  output logic [ADDR_W:0]   rd_count
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wgray_s, wbin_s, count;
  logic [31:0]   wbin_w, rgray_w;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_async), .q(wgray_s)
  );

  assign wbin_w = gray2bin(32'(wgray_s));
  assign wbin_s = wbin_w[PW-1:0];
  assign count  = wbin_s - rbin_q;
  assign empty  = (count == '0);
  assign almost_empty = (count <= ae_level);
  assign rd_fire = rd_en && !empty;

  always_comb begin
    rbin_d  = rbin_q;
    if (rd_fire) rbin_d = rbin_q + 1'b1;
    rgray_w = bin2gray(32'(rbin_d));
    rgray_d = rgray_w[PW-1:0];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign rgray    = rgray_q;
  assign raddr    = rbin_q[ADDR_W-1:0];
  assign rd_count = count;

  // R4: ignored read leaves the pointer in place
  a_r4_hold_when_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rbin_q));
  // R6: accepted read advances the pointer on the same edge
  a_r6_read_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_fire |=> (rbin_q == $past(rbin_q) + 1'b1));
  // R10: one Gray bit per accepted read
  a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_fire |=> ($countones(rgray_q ^ $past(rgray_q)) == 1));
  // R5: empty implies the warning level is also reached
  a_r5_empty_warns: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> almost_empty);
  // R9: read-side count bounded by capacity
  a_r9_count_bound: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_count <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_ae.sv
module dcfifo_ae #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   ae_level,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              almost_empty,
  output logic [ADDR_W:0]   rd_count
);
  logic [ADDR_W:0]   wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire, rd_fire;

  dcf_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_async(rgray),
    .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .full(full)
  );

  dcf_rd_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .ae_level(ae_level),
    .wgray_async(wgray), .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire),
    .empty(empty), .almost_empty(almost_empty), .rd_count(rd_count)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst_n(rrst_n), .re(rd_fire), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/tb_dcfifo_ae.sv
`timescale 1ns/1ps
module tb_dcfifo_ae;
  localparam int DW = 8, AW = 3, SS = 2, DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0]   ae_level = 1;
  logic full, empty, almost_empty;
  logic [DW-1:0] rdata;
  logic [AW:0]   rd_count;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] q[$];
  bit done = 0;

  always #10   wclk = ~wclk;
  always #11.5 rclk = ~rclk;

  dcfifo_ae #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SS)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wdata(wdata), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .ae_level(ae_level),
    .rdata(rdata), .empty(empty), .almost_empty(almost_empty), .rd_count(rd_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1; wdata = d;
    if (!full) q.push_back(d);
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic rd_word(input string req);
    logic [DW-1:0] e;
    bit f;
    @(negedge rclk);
    f = !empty; rd_en = 1; e = '0;
    if (f) e = q.pop_front();
    @(negedge rclk);
    rd_en = 0;
    if (f) chk(rdata == e, req, "rdata", int'(rdata), int'(e));
  endtask

  task automatic settle();
    repeat (SS + 3) @(negedge rclk);
  endtask

  initial begin : main
    int occ;
    repeat (3) @(negedge wclk);
    wrst_n = 1;
    @(negedge rclk); rrst_n = 1;
    @(negedge rclk);
    // R1 reset state
    chk(full == 0, "R1", "full", full, 0);
    chk(empty == 1, "R1", "empty", empty, 1);
    chk(almost_empty == 1, "R1", "almost_empty", almost_empty, 1);
    chk(rd_count == 0, "R1", "rd_count", rd_count, 0);

    // R5 fill from empty with threshold one; R7 lag
    ae_level = 1;
    wr_word(8'hA1);
    @(negedge rclk);
    chk(empty == 1, "R7", "empty right after write", empty, 1);
    settle();
    chk(empty == 0, "R7", "empty released", empty, 0);
    chk(almost_empty == 1, "R5", "ae after one write", almost_empty, 1);
    chk(rd_count == 1, "R9", "rd_count", rd_count, 1);
    wr_word(8'hB2);
    settle();
    chk(almost_empty == 0, "R7", "ae released", almost_empty, 0);
    chk(rd_count == 2, "R9", "rd_count", rd_count, 2);
    rd_word("R2");
    chk(almost_empty == 1, "R6", "ae on read edge", almost_empty, 1);
    rd_word("R2");
    chk(empty == 1, "R6", "empty on read edge", empty, 1);

    // R4 read while empty ignored
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk(rd_count == 0, "R4", "rd_count after empty read", rd_count, 0);
    wr_word(8'h5A);
    settle();
    rd_word("R4");
    chk(empty == 1, "R4", "empty after single read", empty, 1);

    // R8 / R3 fill to capacity, overflow attempt, drain with R5 checks
    ae_level = 3;
    for (int i = 0; i < DEPTH; i++) wr_word(8'(8'h10 + i));
    repeat (SS + 3) @(negedge wclk);
    chk(full == 1, "R8", "full", full, 1);
    wr_word(8'hEE);
    settle();
    chk(rd_count == DEPTH, "R3", "rd_count after dropped write", rd_count, DEPTH);
    chk(q.size() == DEPTH, "R3", "model depth", q.size(), DEPTH);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      rd_word("R2");
      chk(almost_empty == (k <= 3), "R5", "ae while draining", almost_empty, int'(k <= 3));
    end
    repeat (SS + 3) @(negedge wclk);
    chk(full == 0, "R8", "full released", full, 0);

    // Random traffic with concurrent checks
    ae_level = 2;
    fork
      begin : writer
        for (int c = 0; c < 3000; c++) begin
          @(negedge wclk);
          chk(!(q.size() >= DEPTH && !full), "R8", "full at capacity", full, 1);
          wr_en = ($urandom % 100) < 55;
          wdata = DW'($urandom);
          if (wr_en && !full) q.push_back(wdata);
        end
        @(negedge wclk); wr_en = 0;
      end
      begin : reader
        bit have = 0;
        logic [DW-1:0] e = '0;
        int idle = 0;
        for (int c = 0; c < 200000 && idle < 40; c++) begin
          @(negedge rclk);
          if (have) chk(rdata == e, "R2", "random rdata", int'(rdata), int'(e));
          have = 0;
          occ = q.size();
          if (occ <= int'(ae_level))
            chk(almost_empty == 1, "R5", "ae at low occupancy", almost_empty, 1);
          if (occ == 0) chk(empty == 1, "R5", "empty at zero", empty, 1);
          rd_en = (c < 3200) ? (($urandom % 100) < 50) : 1'b1;
          if (rd_en && !empty) begin
            e = q.pop_front(); have = 1;
          end
          if (c > 3200 && q.size() == 0 && !have) idle++;
        end
        rd_en = 0;
      end
    join
    settle();
    chk(rd_count == 0, "R9", "rd_count after drain", rd_count, 0);
    chk(q.size() == 0, "R2", "model drained", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule